// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits beside the byte path of a bit-oriented receive channel and enforces a programmable ceiling on frame length. Upstream logic removes the flags and the stuffed bits and then reports each frame at byte level to this block. It reports three things: where the frame starts, each received byte, and where the frame ends. The block counts the bytes of the current frame. When a frame runs past the ceiling, it raises a suspend signal that tells the storage logic to drop the rest of that frame. The overlong frame is then reported the same way as a frame the far end has aborted: a frame-end interrupt pulse, with the abort status bit set.

An 8-bit control register holds the settings. Bit 7 switches checking on or off. Bits 6..0 hold a length code, and the ceiling is that code plus one, times 32 bytes. New settings are picked up at each start of frame, so a frame in progress keeps the ceiling it started with. The byte count keeps running after the ceiling is crossed, so the count reported for an overlong frame is always above the programmed length.

Top module: `rx_len_limiter`

## Requirements
- R1: A write on `cfg_we` stores `cfg_wdata` in the control register. Bit 7 = 1 enables length checking and bit 7 = 0 disables it. Bits 6..0 are the length code RL.
- R2: With checking enabled, the ceiling is (RL+1)*32 bytes (32 to 4096). A frame of exactly the ceiling length is never suspended.
- R3: The first byte beyond the ceiling raises `rx_suspend` in the clock cycle after that byte's strobe. `rx_suspend` stays high until the next start of frame clears it.
- R4: In the same cycle that `rx_suspend` rises, `frame_irq` pulses high for exactly one cycle and `frame_abort` is set. The later end of frame of that frame produces no further pulse.
- R5: `byte_cnt` counts every byte strobed inside a frame, including bytes past the ceiling. A start of frame with no byte clears it to 0.
- R6: `byte_cnt` saturates at 65535 and does not wrap.
- R7: `frame_abort` stays set until a `stat_rd` pulse or the next start of frame clears it.
- R8: With checking disabled, frames of any length are never suspended. `frame_irq` pulses only at end of frame, and `frame_abort` stays clear.
- R9: An end of frame inside a frame that is not suspended gives one `frame_irq` pulse in the following cycle, with `frame_abort` clear.
- R10: The control register is applied at start of frame. A write made during a frame changes only the ceiling of later frames.
- R11: Byte strobes outside a frame (after end of frame, before the next start) leave `byte_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data: bit 7 enable, bits 6..0 length code |
| rx_sof | input | 1 | Start-of-frame marker |
| rx_byte_vld | input | 1 | One received byte per high cycle |
| rx_eof | input | 1 | End-of-frame marker |
| stat_rd | input | 1 | Status read strobe, clears the abort bit |
| rx_suspend | output | 1 | Stop storing data for the current frame |
| frame_irq | output | 1 | One-cycle frame-end interrupt |
| frame_abort | output | 1 | Frame was ended as aborted |
| byte_cnt | output | 16 | Bytes received in the current or last frame |

## Verification
The length check is driven with frames that end exactly at the smallest ceiling, one byte past it, and one byte past the largest ceiling. These three cases separate an off-by-one in the compare from a correct `>` test and show that the code-to-byte scaling is right at both ends of its range. Frames that keep streaming after the overflow show that the counter keeps running while the interrupt does not repeat. A disabled long frame, a write made mid-frame, bytes strobed between frames, and a 65540-byte frame exercise the enable bit, the point at which settings are applied, the gating to in-frame bytes, and saturation.

// File: rtl/rx_len_pkg.sv
package rx_len_pkg;
    localparam int CNT_W    = 16;
    localparam int LEN_W    = 7;
    localparam int BLK_LOG2 = 5;

    typedef struct packed {
        logic             en;
        logic [LEN_W-1:0] code;
    } len_cfg_t;

    typedef struct packed {
        logic in_frame;
        logic suspend;
        logic abort;
        logic irq;
    } ctl_state_t;
endpackage

// File: rtl/rx_len_cfg.sv
module rx_len_cfg
    import rx_len_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [LEN_W:0]     wdata,
    input  logic               sof,
    output len_cfg_t           act_cfg
);
    typedef struct packed {
        len_cfg_t shadow;
        len_cfg_t active;
    } cfg_regs_t;

    cfg_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            r_d.shadow.en   = wdata[LEN_W];
            r_d.shadow.code = wdata[LEN_W-1:0];
        end
        if (sof) begin
            r_d.active = r_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign act_cfg = r_q.active;

    // R10
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(act_cfg));
endmodule

// File: rtl/rx_len_counter.sv
module rx_len_counter
    import rx_len_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] base,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        base  = clr ? '0 : cnt_q;
        cnt_d = base;
        if (inc && (base != CNT_MAX)) begin
            cnt_d = base + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> cnt == '0);
endmodule

// File: rtl/rx_len_cmp.sv
module rx_len_cmp
    import rx_len_pkg::*;
(
    input  len_cfg_t         cfg,
    input  logic [CNT_W-1:0] seen,
    output logic             over
);
    localparam int LIM_W = LEN_W + 1 + BLK_LOG2;

    logic [LIM_W-1:0] limit;

    always_comb begin
        limit = (LIM_W'(cfg.code) + LIM_W'(1)) << BLK_LOG2;
        over  = cfg.en && (seen >= CNT_W'(limit));
    end

    // R2
    limit_range_chk: assert final (limit >= LIM_W'(32) && limit <= LIM_W'(4096));
endmodule

// File: rtl/rx_len_limiter.sv
module rx_len_limiter
    import rx_len_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    input  logic        rx_sof,
    input  logic        rx_byte_vld,
    input  logic        rx_eof,
    input  logic        stat_rd,
    output logic        rx_suspend,
    output logic        frame_irq,
    output logic        frame_abort,
    output logic [15:0] byte_cnt
);
    len_cfg_t         act_cfg;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt;
    logic             over;
    logic             infr;
    logic             accept;
    logic             susp_eff;
    logic             ovf_now;
    logic             end_now;
    ctl_state_t       s_d, s_q;

    rx_len_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .sof     (rx_sof),
        .act_cfg (act_cfg)
    );

    rx_len_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_sof),
        .inc   (accept),
        .base  (base),
        .cnt   (cnt)
    );

    rx_len_cmp u_cmp (
        .cfg  (act_cfg),
        .seen (base),
        .over (over)
    );

    always_comb begin
        infr     = rx_sof || s_q.in_frame;
        accept   = rx_byte_vld && infr;
        susp_eff = rx_sof ? 1'b0 : s_q.suspend;
        ovf_now  = accept && over && !susp_eff;
        end_now  = rx_eof && infr;

        s_d          = s_q;
        s_d.in_frame = end_now ? 1'b0 : infr;
        s_d.suspend  = ovf_now ? 1'b1 : susp_eff;
        if (ovf_now) begin
            s_d.abort = 1'b1;
        end else if (rx_sof || stat_rd) begin
            s_d.abort = 1'b0;
        end
        s_d.irq = ovf_now || (end_now && !susp_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_suspend  = s_q.suspend;
    assign frame_irq   = s_q.irq;
    assign frame_abort = s_q.abort;
    assign byte_cnt    = cnt;

    // R4
    ovf_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_suspend) |-> (frame_irq && frame_abort));

    // R4
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_abort) |-> rx_suspend);

    // R8
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_suspend) |-> act_cfg.en);

    // R3
    sof_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |=> (!rx_suspend && !frame_abort));
endmodule

// File: tb/sim_rx_len_limiter.sv
`timescale 1ns/1ps
module sim_rx_len_limiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        rx_sof = 1'b0;
    logic        rx_byte_vld = 1'b0;
    logic        rx_eof = 1'b0;
    logic        stat_rd = 1'b0;
    logic        rx_suspend;
    logic        frame_irq;
    logic        frame_abort;
    logic [15:0] byte_cnt;

    int checks = 0;
    int errors = 0;
    int irq_n  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rx_len_limiter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld), .rx_eof(rx_eof),
        .stat_rd(stat_rd), .rx_suspend(rx_suspend), .frame_irq(frame_irq),
        .frame_abort(frame_abort), .byte_cnt(byte_cnt)
    );

    always @(negedge clk) if (rst_n && frame_irq) irq_n++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0; #2;
    endtask

    task automatic sof();
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0; #2;
    endtask

    task automatic eof();
        @(negedge clk); rx_eof = 1'b1;
        @(negedge clk); rx_eof = 1'b0; #2;
    endtask

    task automatic rd();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; #2;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_byte_vld = 1'b1;
        end
        @(negedge clk); rx_byte_vld = 1'b0; #2;
    endtask

    task automatic t_reset();
        chk("R5 reset cnt", byte_cnt, 0);
        chk("R3 reset suspend", rx_suspend, 0);
        chk("R7 reset abort", frame_abort, 0);
        chk("R4 reset irq", frame_irq, 0);
    endtask

    task automatic t_exact();
        int i0;
        wr_cfg(8'h80);
        sof();
        bytes(32);
        chk("R2 exact limit no suspend", rx_suspend, 0);
        chk("R5 count 32", byte_cnt, 32);
        i0 = irq_n;
        eof();
        chk("R9 eof irq", irq_n - i0, 1);
        chk("R9 abort clear", frame_abort, 0);
        bytes(5);
        chk("R11 idle bytes ignored", byte_cnt, 32);
    endtask

    task automatic t_over();
        int i0;
        sof();
        i0 = irq_n;
        bytes(33);
        chk("R3 suspend after byte 33", rx_suspend, 1);
        chk("R4 abort set", frame_abort, 1);
        chk("R4 one irq", irq_n - i0, 1);
        bytes(10);
        chk("R5 count past limit", byte_cnt, 43);
        chk("R3 suspend held", rx_suspend, 1);
        eof();
        chk("R4 eof ignored", irq_n - i0, 1);
        chk("R3 suspend held after eof", rx_suspend, 1);
        rd();
        chk("R7 read clears abort", frame_abort, 0);
        sof();
        chk("R3 sof clears suspend", rx_suspend, 0);
        bytes(40);
        chk("R4 abort again", frame_abort, 1);
        eof();
        sof();
        chk("R7 sof clears abort", frame_abort, 0);
        chk("R5 sof clears count", byte_cnt, 0);
        eof();
    endtask

    task automatic t_max();
        wr_cfg(8'hFF);
        sof();
        bytes(4096);
        chk("R2 4096 no suspend", rx_suspend, 0);
        bytes(1);
        chk("R2 4097 suspend", rx_suspend, 1);
        chk("R5 count 4097", byte_cnt, 4097);
        eof();
    endtask

    task automatic t_disabled();
        int i0;
        wr_cfg(8'h00);
        sof();
        i0 = irq_n;
        bytes(200);
        chk("R8 no suspend", rx_suspend, 0);
        chk("R8 no irq midframe", irq_n - i0, 0);
        eof();
        chk("R8 eof irq", irq_n - i0, 1);
        chk("R8 abort clear", frame_abort, 0);
    endtask

    task automatic t_midwrite();
        wr_cfg(8'h80);
        sof();
        bytes(10);
        wr_cfg(8'h81);
        bytes(23);
        chk("R10 old limit kept", rx_suspend, 1);
        chk("R1 enable bit honoured", frame_abort, 1);
        eof();
        sof();
        bytes(64);
        chk("R10 new limit 64", rx_suspend, 0);
        bytes(1);
        chk("R10 byte 65 suspends", rx_suspend, 1);
        eof();
    endtask

    task automatic t_sat();
        wr_cfg(8'h00);
        sof();
        bytes(65540);
        chk("R6 saturate", byte_cnt, 65535);
        eof();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        t_reset();
        t_exact();
        t_over();
        t_max();
        t_disabled();
        t_midwrite();
        t_sat();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule